// File: doc/BRIEF.md
# MSI Interrupt Remapping Unit

This block takes message-signalled interrupt writes, each an address/data pair presented with a valid/ready handshake. It turns each one into a delivery request for the local interrupt controllers. A request carries a 32-bit destination ID, an 8-bit vector, a 3-bit delivery mode and a 1-bit destination mode. Device interrupts and interrupts from the I/O interrupt controller use the same path and are treated the same way.

A global enable chooses how a message is turned into a request. With remapping off, the request fields come straight from the message, and the destination is an 8-bit ID widened with zeros. With remapping on, a 16-bit handle carried in the address selects one entry of an on-chip translation table. That entry supplies the full 32-bit destination, the vector and both mode fields. Lookups that miss raise a one-cycle fault pulse that reports the handle, and the message is dropped. The table is written through a simple indexed write port.

Top module: `msi_remap_unit`

## Requirements
- R1: After reset, out_valid and fault_valid are 0 and in_ready is 1.
- R2: In legacy mode (remap_en=0 at acceptance), out_dest is address bits 19:12 zero-extended to 32 bits, out_vector is data bits 7:0, out_dmode is data bits 10:8 and out_destmode is address bit 2.
- R3: In remapping mode, the handle is address bits 19:4. out_dest, out_vector, out_dmode and out_destmode come from the table entry at that handle, and the message data has no effect on them.
- R4: A remapped handle at or above TBL_DEPTH produces fault_valid for exactly one cycle with fault_handle equal to the handle, and no out_valid.
- R5: A remapped handle that selects an entry whose present bit is 0 produces fault_valid for one cycle with the handle on fault_handle, and no out_valid.
- R6: The outcome of an accepted message appears on the cycle after acceptance: either out_valid or fault_valid, never both.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_valid and all out_* fields hold steady.
- R8: A table write is seen by lookups accepted on a later cycle. A lookup accepted in the same cycle as the write sees the previous contents.
- R9: remap_en is sampled at acceptance. Changing it afterwards does not alter a request already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remap_en | input | 1 | 1 = translate through the table, 0 = legacy pass-through |
| in_valid | input | 1 | Message offered |
| in_ready | output | 1 | Message can be taken this cycle |
| in_addr | input | 32 | Message address |
| in_data | input | 32 | Message data |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | $clog2(TBL_DEPTH) | Table entry written |
| cfg_present | input | 1 | Entry valid bit |
| cfg_dest | input | 32 | Entry destination ID |
| cfg_vector | input | 8 | Entry vector |
| cfg_dmode | input | 3 | Entry delivery mode |
| cfg_destmode | input | 1 | Entry destination mode |
| out_valid | output | 1 | Delivery request pending |
| out_ready | input | 1 | Downstream takes the request |
| out_dest | output | 32 | Destination ID |
| out_vector | output | 8 | Vector |
| out_dmode | output | 3 | Delivery mode |
| out_destmode | output | 1 | Destination mode |
| fault_valid | output | 1 | One-cycle translation fault pulse |
| fault_handle | output | HANDLE_W | Handle that faulted |

## Verification
The bench builds the unit with TBL_DEPTH=16 and the default 16-bit handle, so every table entry can be programmed and checked. This small depth puts the range boundary within reach: handle 15 is the last one that delivers and handle 16 is the first that faults. Handle 0xFFFF is also tried; its low index bits select a present entry, so only the range compare can reject it. One entry is left non-present to exercise the second fault cause.

// File: rtl/msi_remap_pkg.sv
package msi_remap_pkg;
  localparam int DEST_W  = 32;
  localparam int VEC_W   = 8;
  localparam int DMODE_W = 3;

  typedef struct packed {
    logic               present;
    logic [DEST_W-1:0]  dest;
    logic [VEC_W-1:0]   vector;
    logic [DMODE_W-1:0] dmode;
    logic               destmode;
  } xlate_entry_t;

  localparam int ENTRY_W = $bits(xlate_entry_t);
endpackage

// File: rtl/msi_remap_decode.sv
module msi_remap_decode
  import msi_remap_pkg::*;
#(
  parameter int HANDLE_W = 16
) (
  input  logic [31:0]         addr,
  input  logic [31:0]         data,
  output logic [HANDLE_W-1:0] handle,
  output logic [DEST_W-1:0]   leg_dest,
  output logic [VEC_W-1:0]    leg_vector,
  output logic [DMODE_W-1:0]  leg_dmode,
  output logic                leg_destmode
);
  localparam int HLO = 4;

  always_comb begin
    handle       = addr[HLO +: HANDLE_W];
    leg_dest     = {{(DEST_W-8){1'b0}}, addr[19:12]};
    leg_vector   = data[VEC_W-1:0];
    leg_dmode    = data[8 +: DMODE_W];
    leg_destmode = addr[2];
  end
endmodule

// File: rtl/msi_remap_table.sv
module msi_remap_table
  import msi_remap_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  xlate_entry_t     wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output xlate_entry_t     rdata
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rd_q <= mem[ridx];
  end

  assign rdata = xlate_entry_t'(rd_q);
endmodule

// File: rtl/msi_remap_unit.sv
module msi_remap_unit
  import msi_remap_pkg::*;
#(
  parameter int TBL_DEPTH = 256,
  parameter int HANDLE_W  = 16,
  localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                remap_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [31:0]         in_addr,
  input  logic [31:0]         in_data,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_present,
  input  logic [31:0]         cfg_dest,
  input  logic [7:0]          cfg_vector,
  input  logic [2:0]          cfg_dmode,
  input  logic                cfg_destmode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [31:0]         out_dest,
  output logic [7:0]          out_vector,
  output logic [2:0]          out_dmode,
  output logic                out_destmode,
  output logic                fault_valid,
  output logic [HANDLE_W-1:0] fault_handle
);
  localparam logic [HANDLE_W:0] DEPTH_L = (HANDLE_W+1)'(TBL_DEPTH);

  logic [HANDLE_W-1:0] dec_handle;
  logic [DEST_W-1:0]   dec_dest;
  logic [VEC_W-1:0]    dec_vector;
  logic [DMODE_W-1:0]  dec_dmode;
  logic                dec_destmode;

  msi_remap_decode #(.HANDLE_W(HANDLE_W)) u_dec (
    .addr(in_addr), .data(in_data), .handle(dec_handle),
    .leg_dest(dec_dest), .leg_vector(dec_vector),
    .leg_dmode(dec_dmode), .leg_destmode(dec_destmode)
  );

  logic         accept;
  xlate_entry_t wr_entry, rd_entry;

  always_comb begin
    wr_entry.present  = cfg_present;
    wr_entry.dest     = cfg_dest;
    wr_entry.vector   = cfg_vector;
    wr_entry.dmode    = cfg_dmode;
    wr_entry.destmode = cfg_destmode;
  end

  msi_remap_table #(.DEPTH(TBL_DEPTH)) u_tbl (
    .clk(clk), .we(cfg_we), .widx(cfg_idx), .wdata(wr_entry),
    .re(accept), .ridx(dec_handle[IDX_W-1:0]), .rdata(rd_entry)
  );

  // Stage-1 state: message accepted last cycle
  logic                s1_valid, s1_remap, s1_inrange;
  logic [HANDLE_W-1:0] s1_handle;
  logic [DEST_W-1:0]   s1_dest;
  logic [VEC_W-1:0]    s1_vector;
  logic [DMODE_W-1:0]  s1_dmode;
  logic                s1_destmode;
  logic                hit;

  assign hit         = s1_inrange && rd_entry.present;
  assign out_valid   = s1_valid && (!s1_remap || hit);
  assign fault_valid = s1_valid && s1_remap && !hit;
  assign fault_handle = s1_handle;
  assign in_ready    = !s1_valid || fault_valid || out_ready;
  assign accept      = in_valid && in_ready;

  assign out_dest     = s1_remap ? rd_entry.dest     : s1_dest;
  assign out_vector   = s1_remap ? rd_entry.vector   : s1_vector;
  assign out_dmode    = s1_remap ? rd_entry.dmode    : s1_dmode;
  assign out_destmode = s1_remap ? rd_entry.destmode : s1_destmode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (accept) begin
      s1_valid <= 1'b1;
    end else if (fault_valid || (out_valid && out_ready)) begin
      s1_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_remap    <= 1'b0;
      s1_inrange  <= 1'b0;
      s1_handle   <= '0;
      s1_dest     <= '0;
      s1_vector   <= '0;
      s1_dmode    <= '0;
      s1_destmode <= 1'b0;
    end else if (accept) begin
      s1_remap    <= remap_en;
      s1_inrange  <= {1'b0, dec_handle} < DEPTH_L;
      s1_handle   <= dec_handle;
      s1_dest     <= dec_dest;
      s1_vector   <= dec_vector;
      s1_dmode    <= dec_dmode;
      s1_destmode <= dec_destmode;
    end
  end

  // R1: with nothing held, the input side is open
  p_idle_open_r1: assert property (@(posedge clk) disable iff (rst)
    !out_valid && !fault_valid |-> in_ready);

  // R2: legacy requests never carry more than an 8-bit destination
  p_legacy_narrow_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !s1_remap |-> out_dest[31:8] == '0);

  // R4: out-of-range handles never deliver
  p_range_fault_r4: assert property (@(posedge clk) disable iff (rst)
    s1_valid && s1_remap && !s1_inrange |-> fault_valid && !out_valid);

  // R4/R5: a fault lasts one cycle unless a new message was taken
  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    fault_valid && !in_valid |=> !fault_valid);

  // R6: outcome on the next cycle, exclusive
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_valid ^ fault_valid));

  // R7: held request stays put under back-pressure
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_dest) &&
      $stable(out_vector) && $stable(out_dmode) && $stable(out_destmode));

  p_block_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/msi_remap_unit_test.sv
module msi_remap_unit_test;
  localparam int DEPTH = 16;
  localparam int IW    = $clog2(DEPTH);
  localparam int NV    = 10;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic remap_en = 0, in_valid = 0, in_ready;
  logic [31:0] in_addr = 0, in_data = 0;
  logic cfg_we = 0, cfg_present = 0, cfg_destmode = 0;
  logic [IW-1:0] cfg_idx = 0;
  logic [31:0] cfg_dest = 0;
  logic [7:0] cfg_vector = 0;
  logic [2:0] cfg_dmode = 0;
  logic out_valid, out_ready = 1, out_destmode, fault_valid;
  logic [31:0] out_dest;
  logic [7:0] out_vector;
  logic [2:0] out_dmode;
  logic [15:0] fault_handle;

  msi_remap_unit #(.TBL_DEPTH(DEPTH), .HANDLE_W(16)) uut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  logic        sh_p [DEPTH];
  logic [31:0] sh_d [DEPTH];
  logic [7:0]  sh_v [DEPTH];
  logic [2:0]  sh_m [DEPTH];
  logic        sh_dm[DEPTH];

  // {remap_en, addr, data}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'hFEE0_3004, 32'h0000_0541},
    {1'b0, 32'hFEEA_B000, 32'h0000_02FF},
    {1'b1, 32'hFEE0_0020, 32'h0000_DEAD},
    {1'b1, 32'hFEE0_0020, 32'h0000_1234},
    {1'b1, 32'hFEE0_00F0, 32'h0000_0000},
    {1'b1, 32'hFEE0_0100, 32'h0000_0011},
    {1'b1, 32'hFEE0_0050, 32'h0000_0022},
    {1'b1, 32'hFEEF_FFF0, 32'h0000_0033},
    {1'b0, 32'hFEEF_FFF0, 32'h0000_0700},
    {1'b1, 32'hFEE0_0000, 32'h0000_0044}
  };

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic p, input logic [31:0] d,
                    input logic [7:0] v, input logic [2:0] m, input logic dm);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(i); cfg_present = p; cfg_dest = d;
    cfg_vector = v; cfg_dmode = m; cfg_destmode = dm;
    @(posedge clk); #1;
    cfg_we = 0;
    sh_p[i] = p; sh_d[i] = d; sh_v[i] = v; sh_m[i] = m; sh_dm[i] = dm;
  endtask

  // Expected outcome from the requirements and the bench's own table copy
  task automatic model(input logic en, input logic [31:0] a, input logic [31:0] d,
                       output bit flt, output logic [63:0] exp, output string req);
    logic [15:0] h;
    h = a[19:4];
    flt = 0;
    if (!en) begin
      exp = {20'd0, 32'(a[19:12]), d[7:0], d[10:8], a[2]};
      req = "R2";
    end else if (h >= DEPTH) begin
      flt = 1; exp = 64'(h); req = "R4";
    end else if (!sh_p[h]) begin
      flt = 1; exp = 64'(h); req = "R5";
    end else begin
      exp = {20'd0, sh_d[h], sh_v[h], sh_m[h], sh_dm[h]};
      req = "R3";
    end
  endtask

  // Offer one message; return at the negedge after it was accepted
  task automatic send(input logic en, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    remap_en = en; in_addr = a; in_data = d; in_valid = 1;
    check(!out_valid && !fault_valid, "R6 nothing before accept",
          {fault_valid, out_valid}, 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [63:0] outs();
    return {20'd0, out_dest, out_vector, out_dmode, out_destmode};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit flt;
    logic [63:0] exp, held;
    string req;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !fault_valid && in_ready, "R1 reset state",
          {out_valid, fault_valid, in_ready}, 3'b001);
    rst = 0;
    @(negedge clk);
    check(!out_valid && !fault_valid && in_ready, "R1 after reset",
          {out_valid, fault_valid, in_ready}, 3'b001);

    for (int i = 0; i < DEPTH; i++)
      wr(i, i != 5, 32'h1000_0000 + 32'(i) * 32'h0101_0101,
         8'h20 + 8'(i), 3'(i % 8), i[0]);

    // Vector table walk
    for (int k = 0; k < NV; k++) begin
      model(VEC[k][64], VEC[k][63:32], VEC[k][31:0], flt, exp, req);
      send(VEC[k][64], VEC[k][63:32], VEC[k][31:0]);
      if (flt) begin
        check(fault_valid && !out_valid && 64'(fault_handle) == exp,
              $sformatf("%s fault vec %0d", req, k), 64'(fault_handle), exp);
        @(negedge clk);
        check(!fault_valid && !out_valid, $sformatf("%s single pulse vec %0d", req, k),
              {fault_valid, out_valid}, 0);
      end else begin
        check(out_valid && !fault_valid && outs() == exp,
              $sformatf("%s R6 deliver vec %0d", req, k), outs(), exp);
        @(negedge clk);
        check(!out_valid, $sformatf("R6 consumed vec %0d", k), 64'(out_valid), 0);
      end
    end

    // Back-pressure
    out_ready = 0;
    send(0, 32'hFEE4_2004, 32'h0000_0333);
    held = outs();
    check(out_valid && !in_ready, "R7 blocked", {out_valid, in_ready}, 2'b10);
    in_valid = 1; remap_en = 1; in_addr = 32'hFEE0_0030; in_data = 32'h99;
    repeat (3) @(negedge clk);
    check(out_valid && outs() == held && !in_ready, "R7 held", outs(), held);
    in_valid = 0;
    out_ready = 1;
    @(negedge clk);
    check(!out_valid, "R7 released", 64'(out_valid), 0);

    // Mode change after acceptance
    out_ready = 0;
    model(1, 32'hFEE0_0090, 0, flt, exp, req);
    send(1, 32'hFEE0_0090, 32'h0);
    remap_en = 0;
    @(negedge clk);
    check(out_valid && outs() == exp, "R9 mode sampled at accept", outs(), exp);
    out_ready = 1;
    @(negedge clk);

    // Write in the same cycle as a lookup of that entry
    model(1, 32'hFEE0_0030, 0, flt, exp, req);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3; cfg_present = 1; cfg_dest = 32'hCAFE_0003;
    cfg_vector = 8'hE3; cfg_dmode = 3'd6; cfg_destmode = 1'b1;
    remap_en = 1; in_addr = 32'hFEE0_0030; in_data = 0; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    sh_d[3] = 32'hCAFE_0003; sh_v[3] = 8'hE3; sh_m[3] = 3'd6; sh_dm[3] = 1'b1;
    check(out_valid && outs() == exp, "R8 same-cycle write unseen", outs(), exp);
    @(negedge clk);
    model(1, 32'hFEE0_0030, 0, flt, exp, req);
    send(1, 32'hFEE0_0030, 32'h0);
    check(out_valid && outs() == exp, "R8 later lookup sees write", outs(), exp);
    @(negedge clk);

    // Clearing presence turns a hit into a fault
    wr(2, 0, 0, 0, 0, 0);
    send(1, 32'hFEE0_0020, 32'h0);
    check(fault_valid && !out_valid && fault_handle == 16'd2, "R5 cleared entry",
          64'(fault_handle), 2);
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule